// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver

This block receives bytes from a serial peripheral bus master as a slave. All of its logic runs on the system clock. The serial clock, the active-low select and the serial data pins are sampled through a short flip-flop chain, and no flop is ever clocked by the serial clock. A rising edge of the sampled serial clock, seen while the sampled select is low, shifts one sampled data bit into the byte register. The most significant bit arrives first.

When the select line is released, the block checks how many bits arrived since the frame began. Exactly `DATA_W` bits form a byte, which goes to the output stage. Any other count is thrown away without a trace.

The output is a valid/ready stream. A byte is offered with `out_valid` high and stays offered, unchanged, until the consumer raises `out_ready`. The serial master cannot be stalled. A byte that completes while an earlier byte is still waiting is therefore dropped, and the waiting byte is kept. A consumer that holds `out_ready` high sees a valid pulse one cycle long for each byte.

Top module: `spi_byte_rx`

## Requirements
- R1: In the cycle after a synchronous reset, `out_valid` is 0 and `out_data` is 0.
- R2: Each of the three serial pins passes through a `SYNC_STAGES`-flop chain (default 2). When a complete frame ends, `out_valid` rises at the third system clock edge after `ser_sel_n` goes high. That is `SYNC_STAGES`+1 edges.
- R3: Bits are taken on rising edges of the synchronized serial clock, most significant bit first. The first bit of a frame lands in `out_data[DATA_W-1]` and the last bit lands in `out_data[0]`.
- R4: Serial clock edges while the synchronized select is high shift nothing and count nothing. Every frame starts with a bit count of zero.
- R5: A frame released after fewer than `DATA_W` bits produces no output.
- R6: A frame released after more than `DATA_W` bits produces no output. The bit count saturates at `DATA_W`+1, so long frames cannot wrap back to a full count.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds. A transfer happens on a cycle where both are high. After a transfer, `out_valid` is low in the next cycle unless a new byte loads in that same cycle.
- R8: A byte that completes while `out_valid` is high and `out_ready` is low is discarded, and the waiting byte is kept.
- R9: Reception is correct when each serial clock level lasts at least 4 system clock cycles. This corresponds to a serial clock of at most one eighth of the system clock.
- R10: Frames separated by only one serial half-period of idle select are each delivered, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Serial clock pin, asynchronous, idles low |
| ser_sel_n | input | 1 | Serial select pin, active low, asynchronous |
| ser_din | input | 1 | Serial data pin, asynchronous |
| out_data | output | DATA_W | Received byte |
| out_valid | output | 1 | Byte offered on `out_data` |
| out_ready | input | 1 | Consumer accepts the offered byte |

## Verification
The bench builds the block with `DATA_W` = 8 and `SYNC_STAGES` = 2. The serial clock is driven at exactly four system cycles per level, which is the fastest rate R9 allows. With eight data bits, a ten-bit frame passes the full count and reaches the saturating value, so the check against wrap-back becomes reachable. The two-stage chain fixes the release-to-valid latency at three edges, which the bench samples edge by edge. Holding the consumer back while a second frame arrives brings the drop rule of R8 within reach.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;

  // Bundle of the three serial pins as they pass through synchronization.
  typedef struct packed {
    logic sclk;
    logic sel_n;
    logic din;
  } pins_t;

  // Idle level of each pin: clock low, select released, data low.
  localparam pins_t PINS_IDLE = '{sclk: 1'b0, sel_n: 1'b1, din: 1'b0};

  localparam int PINS_W = $bits(pins_t);

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/edge_track.sv
module edge_track (
  input  logic clk,
  input  logic rst,
  input  logic sclk_s,
  input  logic sel_s,
  output logic shift_en,
  output logic frame_end
);

  logic sclk_prev;
  logic sel_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      sel_prev  <= 1'b1;
    end else begin
      sclk_prev <= sclk_s;
      sel_prev  <= sel_s;
    end
  end

  // A rising serial clock counts only while the select is held low.
  assign shift_en  = sclk_s & ~sclk_prev & ~sel_s;
  assign frame_end = sel_s & ~sel_prev;

endmodule

// File: rtl/frame_assembler.sv
module frame_assembler #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              sel_s,
  input  logic              din_s,
  input  logic              frame_end,
  output logic              load,
  output logic [DATA_W-1:0] byte_q,
  output logic [CNT_W-1:0]  cnt
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(DATA_W + 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_q <= '0;
      cnt    <= '0;
    end else begin
      if (sel_s)                           cnt <= '0;
      else if (shift_en && cnt != CNT_OVER) cnt <= cnt + 1'b1;
      if (shift_en) byte_q <= {byte_q[DATA_W-2:0], din_s};
    end
  end

  assign load = frame_end && (cnt == CNT_FULL);

endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] byte_in,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready
);

  logic slot_free;
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data  <= '0;
      out_valid <= 1'b0;
    end else if (load && slot_free) begin
      out_data  <= byte_in;
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_byte_rx.sv
module spi_byte_rx
  import spi_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_sel_n,
  input  logic              ser_din,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready
);

  localparam int CNT_W = $clog2(DATA_W + 2);

  pins_t             pins_raw;
  pins_t             pins_s;
  logic [PINS_W-1:0] sync_q;
  logic              sel_sync;
  logic              shift_en;
  logic              frame_end;
  logic              load_byte;
  logic [DATA_W-1:0] asm_byte;
  logic [CNT_W-1:0]  bit_cnt;

  assign pins_raw = '{sclk: ser_clk, sel_n: ser_sel_n, din: ser_din};

  bit_sync #(
    .WIDTH  (PINS_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PINS_IDLE)
  ) i_sync (
    .clk(clk),
    .rst(rst),
    .d  (pins_raw),
    .q  (sync_q)
  );

  assign pins_s   = pins_t'(sync_q);
  assign sel_sync = pins_s.sel_n;

  edge_track i_edge (
    .clk      (clk),
    .rst      (rst),
    .sclk_s   (pins_s.sclk),
    .sel_s    (sel_sync),
    .shift_en (shift_en),
    .frame_end(frame_end)
  );

  frame_assembler #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) i_asm (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .sel_s    (sel_sync),
    .din_s    (pins_s.din),
    .frame_end(frame_end),
    .load     (load_byte),
    .byte_q   (asm_byte),
    .cnt      (bit_cnt)
  );

  out_stage #(
    .DATA_W(DATA_W)
  ) i_out (
    .clk      (clk),
    .rst      (rst),
    .load     (load_byte),
    .byte_in  (asm_byte),
    .out_data (out_data),
    .out_valid(out_valid),
    .out_ready(out_ready)
  );

endmodule

// File: rtl/spi_byte_rx_chk.sv
module spi_byte_rx_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              shift_en,
  input logic              sel_sync,
  input logic              load_byte,
  input logic [CNT_W-1:0]  bit_cnt
);

  // R4: no shift is ever enabled while the synchronized select is high
  p_idle_no_shift_r4: assert property (@(posedge clk) disable iff (rst)
    sel_sync |-> !shift_en);

  // R4: a high select leaves the bit count at zero
  p_count_cleared_r4: assert property (@(posedge clk) disable iff (rst)
    sel_sync |=> bit_cnt == '0);

  // R6: the count never passes the saturation value
  p_count_bounded_r6: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(DATA_W + 1));

  // R7 and R8: an offered byte holds until it is taken
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R7: a taken byte clears the offer unless a new byte loads
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !load_byte |=> !out_valid);

endmodule

bind spi_byte_rx spi_byte_rx_chk #(
  .DATA_W(DATA_W),
  .CNT_W (CNT_W)
) i_chk (
  .clk      (clk),
  .rst      (rst),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .shift_en (shift_en),
  .sel_sync (sel_sync),
  .load_byte(load_byte),
  .bit_cnt  (bit_cnt)
);

// File: tb/test_spi_byte_rx.sv
module test_spi_byte_rx;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;
  localparam int HALF       = 4;   // system cycles per serial clock level

  logic              clk = 1'b0;
  logic              rst;
  logic              ser_clk;
  logic              ser_sel_n;
  logic              ser_din;
  logic [DATA_W-1:0] out_data;
  logic              out_valid;
  logic              out_ready;

  int checks = 0;
  int fails  = 0;
  int rx_n   = 0;
  logic [DATA_W-1:0] rx_log [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_byte_rx #(.DATA_W(DATA_W), .SYNC_STAGES(2)) i_spi_byte_rx (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
    .ser_din(ser_din), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready)
  );

  // Record every completed transfer.
  always @(negedge clk)
    if (!rst && out_valid && out_ready && rx_n < 64) begin
      rx_log[rx_n] = out_data;
      rx_n++;
    end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Select low, then clock out nbits of 'bits' from the most significant used bit.
  task automatic send_bits(input logic [15:0] bits, input int nbits);
    ser_sel_n = 1'b0;
    idle(HALF);
    for (int i = nbits - 1; i >= 0; i--) begin
      ser_din = bits[i];
      idle(HALF);
      ser_clk = 1'b1;
      idle(HALF);
      ser_clk = 1'b0;
    end
    idle(HALF);
  endtask

  task automatic release_sel();
    ser_sel_n = 1'b1;
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R1 valid", out_valid, 0);
    chk(out_data == '0, "R1 data", out_data, 0);
  endtask

  // Exact latency and one-cycle pulse with ready held high.
  task automatic t_byte(input logic [7:0] b, input string req);
    int n0 = rx_n;
    send_bits({8'h00, b}, 8);
    release_sel();
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(out_valid == 1'b0, "R2 early", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R2 third edge", out_valid, 1);
    chk(out_data == b, req, out_data, b);
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 pulse", out_valid, 0);
    chk(rx_n == n0 + 1, "R9 one byte", rx_n - n0, 1);
    idle(HALF);
  endtask

  task automatic t_bad_len(input int nbits, input string req);
    int n0 = rx_n;
    send_bits(16'hB6D5, nbits);
    release_sel();
    idle(12);
    chk(rx_n == n0 && !out_valid, req, rx_n - n0, 0);
  endtask

  // Clock activity while deselected, then a 4-bit frame: a count kept
  // across the idle gap would reach eight and emit a byte.
  task automatic t_idle_clock();
    int n0 = rx_n;
    for (int i = 0; i < 4; i++) begin
      ser_din = 1'b1;
      idle(HALF); ser_clk = 1'b1;
      idle(HALF); ser_clk = 1'b0;
    end
    send_bits(16'h000A, 4);
    release_sel();
    idle(12);
    chk(rx_n == n0, "R4 idle clock", rx_n - n0, 0);
    send_bits(16'h005A, 8);
    release_sel();
    idle(12);
    chk(rx_n == n0 + 1 && rx_log[n0] == 8'h5A, "R4 next frame", rx_log[n0], 8'h5A);
  endtask

  task automatic t_backpressure();
    bit held = 1'b1;
    int n0 = rx_n;
    out_ready = 1'b0;
    send_bits(16'h003C, 8);
    release_sel();
    idle(4);
    chk(out_valid && out_data == 8'h3C, "R7 offered", out_data, 8'h3C);
    ser_sel_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      ser_din = (i < 4);
      idle(HALF); ser_clk = 1'b1;
      if (!out_valid || out_data != 8'h3C) held = 1'b0;
      idle(HALF); ser_clk = 1'b0;
    end
    idle(HALF);
    release_sel();
    idle(10);
    chk(held && out_valid, "R7 held", held, 1);
    chk(out_data == 8'h3C, "R8 kept", out_data, 8'h3C);
    out_ready = 1'b1;
    @(negedge clk);
    chk(rx_n == n0 + 1 && rx_log[n0] == 8'h3C, "R7 transfer", rx_log[n0], 8'h3C);
    chk(out_valid == 1'b0, "R7 cleared", out_valid, 0);
    idle(10);
    chk(rx_n == n0 + 1, "R8 dropped", rx_n - n0, 1);
  endtask

  task automatic t_back_to_back();
    int n0 = rx_n;
    send_bits(16'h0012, 8);
    release_sel();
    idle(HALF);
    send_bits(16'h00C3, 8);
    release_sel();
    idle(12);
    chk(rx_n == n0 + 2, "R10 count", rx_n - n0, 2);
    chk(rx_log[n0] == 8'h12 && rx_log[n0+1] == 8'hC3, "R10 order",
        {rx_log[n0], rx_log[n0+1]}, 16'h12C3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; ser_clk = 1'b0; ser_sel_n = 1'b1; ser_din = 1'b0; out_ready = 1'b1;
    idle(4);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_byte(8'hA5, "R3 pattern A5");
    t_byte(8'h80, "R3 msb first");
    t_byte(8'h01, "R3 lsb last");
    t_bad_len(5, "R5 short frame");
    t_bad_len(10, "R6 long frame");
    t_byte(8'h96, "R6 recovery");
    t_idle_clock();
    t_backpressure();
    t_back_to_back();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule